// File: doc/BRIEF.md
# Translation Lookaside Buffer with Modified and Referenced Tracking

This block is a small fully associative translation buffer. Each load or store presents a virtual page number. One cycle later the block answers with exactly one of three outcomes. A hit returns the physical frame number. A miss means no entry holds that page. A trap means an entry exists but its permission forbids the access. Each entry also carries two bookkeeping flags. The modified flag is set by hardware when a store hits a writable entry. The referenced flag is set when a page that just missed is then installed. Both flags appear on every response, so the page-table copy can be kept current.

A kernel-side agent manages the table through a one-cycle command port: install an entry, invalidate an entry, or clear an entry's bookkeeping flags. A small state machine tracks refills. It sits in `ST_RUN` until a lookup misses. That transition records the missing page and moves it to `ST_AWAIT_FILL`. An install of that same page sets the new entry's referenced flag and takes it back to `ST_RUN`. A later miss while in `ST_AWAIT_FILL` replaces the recorded page. Read-only and no-access entries let software emulate both flags through traps.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, no entry is present, `rsp_valid` is 0, and any lookup misses.
- R2: A request sampled at a clock edge gets its response, with `rsp_valid` high, after that same edge. Exactly one of `rsp_hit`, `rsp_miss` and `rsp_trap` is set. `rsp_pfn` carries the frame on a hit and is 0 otherwise. With no request, `rsp_valid` and all outcome flags are 0.
- R3: A store to a present entry with access 2'b11 (read/write) is a hit. It sets that entry's modified flag, and `rsp_dirty` reports 1 on the same response.
- R4: A store to an entry with access 2'b01 (read-only) traps and leaves the modified flag at 0. A load of that entry hits. Access 2'b10 behaves like 2'b01.
- R5: Any load or store to a present entry with access 2'b00 traps.
- R6: After a miss on page V, an install of V sets that entry's referenced flag, reported on `rsp_use`. An install with no pending miss for its page leaves the flag at 0. Every install clears the modified flag.
- R7: Command 2'b11 clears the modified and referenced flags of the entry matching `mgmt_vpn`. The frame number and access field are kept.
- R8: Command 2'b10 removes the entry matching `mgmt_vpn`, so a following lookup of that page misses.
- R9: Command 2'b01 installs a new page into the lowest-numbered empty slot. When all slots are full, it uses a round-robin victim that starts at slot 0 and advances by one on each such replacement.
- R10: An install of a page that is already present overwrites that entry in place. A page never occupies two slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | 1 for store, 0 for load |
| req_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation allowed |
| rsp_miss | output | 1 | No entry for the page |
| rsp_trap | output | 1 | Entry present, access denied |
| rsp_pfn | output | PFN_W | Physical frame on hit, else 0 |
| rsp_dirty | output | 1 | Modified flag of the entry after the access |
| rsp_use | output | 1 | Referenced flag of the entry |
| mgmt_op | input | 2 | 00 none, 01 install, 10 invalidate, 11 clear flags |
| mgmt_vpn | input | VPN_W | Page the command applies to |
| mgmt_pfn | input | PFN_W | Frame for install |
| mgmt_acc | input | 2 | Access field for install |

## Verification
The assertions check the response timing and the exclusivity of the outcome flags on every cycle. They also check that a store hit always reports a set modified flag, that a trapped store never does, and that neither the lookup nor the command-side compare ever matches more than one slot. Only the bench scenarios can show the rest. These are the refill-driven setting of the referenced flag, the flag clearing that keeps frame and access, invalidation turning a hit into a miss, the order in which slots are refilled, and in-place overwrite.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        MG_NOP     = 2'b00,
        MG_INSTALL = 2'b01,
        MG_INVAL   = 2'b10,
        MG_CLRBITS = 2'b11
    } mgmt_op_t;

    typedef enum logic {
        ST_RUN,
        ST_AWAIT_FILL
    } fill_state_t;

    localparam logic [1:0] ACC_NONE = 2'b00;
    localparam logic [1:0] ACC_RW   = 2'b11;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N    = 8,
    parameter int VW   = 20,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  present,
    input  logic [VW-1:0] tab_vpn [N],
    input  logic [VW-1:0] key,
    output logic [N-1:0]  match,
    output logic          any,
    output logic [IW-1:0] idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = present[g] && (tab_vpn[g] == key);
    end

    assign any = |match;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N   = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  present,
    input  logic          advance,
    output logic          full,
    output logic [IW-1:0] victim
);
    logic [IW-1:0] rr_q;
    logic [IW-1:0] free_idx;

    assign full = &present;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!present[i]) free_idx = IW'(i);
        end
    end

    assign victim = full ? rr_q : free_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance && full) begin
            rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_trap,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic             rsp_dirty,
    output logic             rsp_use,
    input  logic [1:0]       mgmt_op,
    input  logic [VPN_W-1:0] mgmt_vpn,
    input  logic [PFN_W-1:0] mgmt_pfn,
    input  logic [1:0]       mgmt_acc
);
    logic [ENTRIES-1:0] ent_present;
    logic [VPN_W-1:0]   ent_vpn [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn [ENTRIES];
    logic [1:0]         ent_acc [ENTRIES];
    logic [ENTRIES-1:0] ent_dirty;
    logic [ENTRIES-1:0] ent_use;

    logic [ENTRIES-1:0] lk_match, mg_match;
    logic               lk_any, mg_any;
    logic [IW-1:0]      lk_idx, mg_idx, victim_idx, tgt_idx;
    logic               tab_full;

    mgmt_op_t    op;
    fill_state_t state_q, state_d;
    logic [VPN_W-1:0] pend_vpn_q;
    logic        fill_match;

    assign op = mgmt_op_t'(mgmt_op);

    tlb_cam #(.N(ENTRIES), .VW(VPN_W)) u_cam_lookup (
        .present(ent_present), .tab_vpn(ent_vpn), .key(req_vpn),
        .match(lk_match), .any(lk_any), .idx(lk_idx)
    );

    tlb_cam #(.N(ENTRIES), .VW(VPN_W)) u_cam_mgmt (
        .present(ent_present), .tab_vpn(ent_vpn), .key(mgmt_vpn),
        .match(mg_match), .any(mg_any), .idx(mg_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .present(ent_present),
        .advance((op == MG_INSTALL) && !mg_any),
        .full(tab_full), .victim(victim_idx)
    );

    assign tgt_idx = mg_any ? mg_idx : victim_idx;

    // Lookup decode on the pre-update table
    logic [1:0] lk_acc;
    logic       lk_trap, lk_hit, lk_wr_hit;
    assign lk_acc    = ent_acc[lk_idx];
    assign lk_trap   = lk_any && ((lk_acc == ACC_NONE) || (req_write && lk_acc != ACC_RW));
    assign lk_hit    = lk_any && !lk_trap;
    assign lk_wr_hit = req_valid && req_write && lk_hit;

    // Refill tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            pend_vpn_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid && !lk_any) pend_vpn_q <= req_vpn;
        end
    end

    // Refill tracker: next state and outputs
    always_comb begin
        state_d    = state_q;
        fill_match = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (req_valid && !lk_any) state_d = ST_AWAIT_FILL;
            end
            ST_AWAIT_FILL: begin
                fill_match = (op == MG_INSTALL) && (mgmt_vpn == pend_vpn_q);
                if (req_valid && !lk_any) state_d = ST_AWAIT_FILL;
                else if (fill_match)     state_d = ST_RUN;
            end
        endcase
    end

    // Entry table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_present <= '0;
            ent_dirty   <= '0;
            ent_use     <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_vpn[i] <= '0;
                ent_pfn[i] <= '0;
                ent_acc[i] <= ACC_NONE;
            end
        end else begin
            if (lk_wr_hit) ent_dirty[lk_idx] <= 1'b1;
            unique case (op)
                MG_NOP: ;
                MG_INSTALL: begin
                    ent_present[tgt_idx] <= 1'b1;
                    ent_vpn[tgt_idx]     <= mgmt_vpn;
                    ent_pfn[tgt_idx]     <= mgmt_pfn;
                    ent_acc[tgt_idx]     <= mgmt_acc;
                    ent_dirty[tgt_idx]   <= 1'b0;
                    ent_use[tgt_idx]     <= fill_match;
                end
                MG_INVAL: begin
                    if (mg_any) ent_present[mg_idx] <= 1'b0;
                end
                MG_CLRBITS: begin
                    if (mg_any) begin
                        ent_dirty[mg_idx] <= 1'b0;
                        ent_use[mg_idx]   <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_trap  <= 1'b0;
            rsp_pfn   <= '0;
            rsp_dirty <= 1'b0;
            rsp_use   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && lk_hit;
            rsp_miss  <= req_valid && !lk_any;
            rsp_trap  <= req_valid && lk_trap;
            rsp_pfn   <= (req_valid && lk_hit) ? ent_pfn[lk_idx] : '0;
            rsp_dirty <= req_valid && lk_any && (ent_dirty[lk_idx] || lk_wr_hit);
            rsp_use   <= req_valid && lk_any && ent_use[lk_idx];
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         req_write,
    input logic         rsp_valid,
    input logic         rsp_hit,
    input logic         rsp_miss,
    input logic         rsp_trap,
    input logic         rsp_dirty,
    input logic [N-1:0] lk_match,
    input logic [N-1:0] mg_match
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_trap}) == 1); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_trap)); // R2
    AST_STORE_HIT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_write) |=> (rsp_hit -> rsp_dirty)); // R3
    AST_STORE_TRAP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_write) |=> (rsp_trap -> !rsp_dirty)); // R4
    AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_match)); // R10
    AST_MGMT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mg_match)); // R10
endmodule

bind tlb_xlate tlb_xlate_chk #(.N(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_trap(rsp_trap), .rsp_dirty(rsp_dirty),
    .lk_match(lk_match), .mg_match(mg_match)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
    localparam int VW = 20;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [VW-1:0] req_vpn = '0;
    logic          rsp_valid, rsp_hit, rsp_miss, rsp_trap, rsp_dirty, rsp_use;
    logic [PW-1:0] rsp_pfn;
    logic [1:0]    mgmt_op = 2'b00, mgmt_acc = 2'b00;
    logic [VW-1:0] mgmt_vpn = '0;
    logic [PW-1:0] mgmt_pfn = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tlb_xlate i_tlb_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_vpn(req_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_trap(rsp_trap), .rsp_pfn(rsp_pfn), .rsp_dirty(rsp_dirty),
        .rsp_use(rsp_use),
        .mgmt_op(mgmt_op), .mgmt_vpn(mgmt_vpn), .mgmt_pfn(mgmt_pfn),
        .mgmt_acc(mgmt_acc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // outcome code: 1 hit, 2 miss, 4 trap
    task automatic access(input logic [VW-1:0] v, input logic wr, input string req,
                          input logic [2:0] exp_out, input logic [PW-1:0] exp_pfn,
                          input logic exp_dirty, input logic exp_use);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vpn = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " outcome"}, 32'({rsp_trap, rsp_miss, rsp_hit}), 32'(exp_out));
        check({req, " pfn"}, 32'(rsp_pfn), 32'(exp_pfn));
        check({req, " dirty"}, 32'(rsp_dirty), 32'(exp_dirty));
        check({req, " use"}, 32'(rsp_use), 32'(exp_use));
    endtask

    task automatic mgmt(input logic [1:0] op, input logic [VW-1:0] v,
                        input logic [PW-1:0] p, input logic [1:0] acc);
        @(negedge clk);
        mgmt_op = op; mgmt_vpn = v; mgmt_pfn = p; mgmt_acc = acc;
        @(negedge clk);
        mgmt_op = 2'b00;
    endtask

    task automatic t_reset;
        check("R1 idle rsp_valid", 32'(rsp_valid), 32'd0);
        access(20'h00100, 1'b0, "R1 empty lookup", 3'b010, '0, 1'b0, 1'b0);
    endtask

    task automatic t_fill_use;
        mgmt(2'b01, 20'h00100, 20'h000A0, 2'b11);
        access(20'h00100, 1'b0, "R6 refill sets use", 3'b001, 20'h000A0, 1'b0, 1'b1);
        access(20'h00100, 1'b0, "R2 hit returns frame", 3'b001, 20'h000A0, 1'b0, 1'b1);
    endtask

    task automatic t_store_dirty;
        access(20'h00100, 1'b1, "R3 store hit", 3'b001, 20'h000A0, 1'b1, 1'b1);
        access(20'h00100, 1'b0, "R3 dirty kept", 3'b001, 20'h000A0, 1'b1, 1'b1);
    endtask

    task automatic t_clear;
        mgmt(2'b11, 20'h00100, '0, 2'b00);
        access(20'h00100, 1'b0, "R7 flags cleared", 3'b001, 20'h000A0, 1'b0, 1'b0);
    endtask

    task automatic t_readonly;
        mgmt(2'b01, 20'h00200, 20'h000B0, 2'b01);
        access(20'h00200, 1'b1, "R4 ro store traps", 3'b100, '0, 1'b0, 1'b0);
        access(20'h00200, 1'b0, "R4 ro load hits", 3'b001, 20'h000B0, 1'b0, 1'b0);
        access(20'h00200, 1'b0, "R6 no pending miss", 3'b001, 20'h000B0, 1'b0, 1'b0);
    endtask

    task automatic t_noaccess;
        mgmt(2'b01, 20'h00300, 20'h000C0, 2'b00);
        access(20'h00300, 1'b0, "R5 load traps", 3'b100, '0, 1'b0, 1'b0);
        access(20'h00300, 1'b1, "R5 store traps", 3'b100, '0, 1'b0, 1'b0);
    endtask

    task automatic t_overwrite;
        mgmt(2'b01, 20'h00200, 20'h000B5, 2'b11);
        access(20'h00200, 1'b1, "R10 overwrite", 3'b001, 20'h000B5, 1'b1, 1'b0);
    endtask

    task automatic t_invalidate;
        mgmt(2'b10, 20'h00300, '0, 2'b00);
        access(20'h00300, 1'b0, "R8 removed page", 3'b010, '0, 1'b0, 1'b0);
    endtask

    task automatic t_replace;
        // slot 2 is free: 0x400 lands there, 0x500..0x900 fill 3..7
        for (int k = 4; k <= 9; k++) begin
            mgmt(2'b01, VW'(k * 256), PW'(k * 16), 2'b11);
        end
        access(20'h00100, 1'b0, "R9 full still hits", 3'b001, 20'h000A0, 1'b0, 1'b0);
        access(20'h00200, 1'b0, "R10 single copy", 3'b001, 20'h000B5, 1'b1, 1'b0);
        mgmt(2'b01, 20'h00A00, 20'h000AA, 2'b11);
        access(20'h00100, 1'b0, "R9 victim slot0", 3'b010, '0, 1'b0, 1'b0);
        access(20'h00200, 1'b0, "R9 slot1 kept", 3'b001, 20'h000B5, 1'b1, 1'b0);
        mgmt(2'b01, 20'h00B00, 20'h000BB, 2'b11);
        access(20'h00200, 1'b0, "R9 victim slot1", 3'b010, '0, 1'b0, 1'b0);
        access(20'h00400, 1'b0, "R9 first free used", 3'b001, 20'h00040, 1'b0, 1'b0);
        access(20'h00A00, 1'b0, "R9 new entry", 3'b001, 20'h000AA, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_use();
        t_store_dirty();
        t_clear();
        t_readonly();
        t_noaccess();
        t_overwrite();
        t_invalidate();
        t_replace();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule